// File: doc/BRIEF.md
# Parallel Adaptive PAM4 Feed-Forward Equalizer

This block equalizes digitized four-level (PAM4) receiver samples several at a time. Each clock with `in_valid` high it takes one block of `LANES` signed 8-bit samples. Lane 0 holds the oldest sample of the block. It runs an `NTAPS`-tap FIR filter on every lane in parallel. For the lowest lanes, the filter taps that reach back past the block edge read the last `NTAPS-1` samples of the previous block, which the block keeps in a history register. Each filtered value is rounded to 8 bits and sliced into a 2-bit PAM4 symbol.

The tap weights adapt in the loop with a sign-sign LMS rule. The slicer error of each lane is compared in sign with the sample each tap saw. The votes are summed over all lanes of the block. Each tap then moves by one step of size 2^-mu against the sign of the summed vote, once per block. The weights clamp at the ends of the coefficient range.

The chip instance runs 64 lanes. The lane count is a parameter, so verification can use a small build.

Top module: `ffe_pam4_top`

## Requirements
- R1: While `rst_n` is low, `taps` holds tap 2 at unity and every other tap at zero. `out_valid`, `eq_out` and `sym_out` are zero. Coefficients are signed 8-bit with 6 fraction bits, so unity is 64. Tap k occupies bits [8k+7:8k].
- R2: For lane i, with x(j) the j-th entry of the sequence formed by the previous block's last `NTAPS-1` samples (oldest first) followed by the current block's lanes, the accumulated value is the sum over k of w[k]·x(`NTAPS-1`+i-k). Lane i occupies bits [8i+7:8i] of `in_samples` and `eq_out`.
- R3: The equalized output is floor((sum + 32) / 64), clamped to the range -128..127.
- R4: The symbol in bits [2i+1:2i] of `sym_out` is chosen from the equalized value y as follows. Code 2'b10 (level +96) when y >= 64. Code 2'b11 (level +32) when 0 <= y < 64. Code 2'b01 (level -32) when -64 <= y < 0. Code 2'b00 (level -96) otherwise.
- R5: `eq_out` and `sym_out` update one cycle after a clock with `in_valid` high. `out_valid` is `in_valid` delayed by one cycle. Without `in_valid`, `eq_out` and `sym_out` hold.
- R6: The history advances only on clocks with `in_valid` high. An idle cycle leaves the next block's filtering unchanged.
- R7: On a clock with `in_valid` and `adapt_en` high, each tap k computes V(k), the sum over lanes of sign(e_i)·sign(x(`NTAPS-1`+i-k)), where e_i = y_i minus the level of its symbol and sign(0) = 0. The tap decreases by s when V(k) > 0 and increases by s when V(k) < 0, with s = 2^(6-min(mu,6)) LSBs.
- R8: An updated tap is clamped to the range -128..127.
- R9: Taps hold whenever `adapt_en` or `in_valid` is low.
- R10: The outputs of a block are computed with the taps in force before that block's own update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| in_valid | input | 1 | A sample block is present |
| in_samples | input | LANES*8 | Signed samples, lane 0 oldest |
| adapt_en | input | 1 | Enables the LMS tap update |
| mu_shift | input | 3 | Step-size exponent |
| out_valid | output | 1 | Outputs refer to a new block |
| eq_out | output | LANES*8 | Equalized samples per lane |
| sym_out | output | LANES*2 | PAM4 symbol codes per lane |
| taps | output | NTAPS*8 | Current tap weights |

## Verification
Filtering and tap adaptation fall in the same clock whenever `adapt_en` is high with a valid block. The outputs of that block must come from the old weights, while the weights seen one cycle later must already carry the update. The bench drives adapting blocks back to back, several with large steps that push a tap into clamping. It compares `eq_out`, `sym_out` and all taps each cycle against a model that filters first and then updates.

// File: rtl/ffe_pkg.sv
package ffe_pkg;
  localparam int SW    = 8;   // sample width
  localparam int CW    = 8;   // coefficient width
  localparam int FRAC  = 6;   // coefficient fraction bits
  localparam int UNITY = 1 << FRAC;
  localparam int MU_MAX = 6;

  function automatic logic [7:0] sat8(input int v);
    if (v > 127)       return 8'h7F;
    else if (v < -128) return 8'h80;
    else               return v[7:0];
  endfunction

  function automatic logic [1:0] slice_sym(input logic [7:0] y);
    int yv;
    yv = int'($signed(y));
    if (yv >= 64)      return 2'b10;
    else if (yv >= 0)  return 2'b11;
    else if (yv >= -64) return 2'b01;
    else               return 2'b00;
  endfunction

  function automatic int sym_level(input logic [1:0] s);
    case (s)
      2'b10:   return 96;
      2'b11:   return 32;
      2'b01:   return -32;
      default: return -96;
    endcase
  endfunction

  // ternary sign code: 01 = +1, 11 = -1, 00 = 0
  function automatic logic [1:0] sgn_code(input logic [7:0] v);
    if (v == 8'h00) return 2'b00;
    else if (v[7])  return 2'b11;
    else            return 2'b01;
  endfunction

  function automatic int sgn_val(input logic [1:0] c);
    case (c)
      2'b01:   return 1;
      2'b11:   return -1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/ffe_history.sv
module ffe_history
  import ffe_pkg::*;
#(
  parameter int LANES = 4,
  parameter int NTAPS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [LANES*SW-1:0]        in_samples,
  output logic [(NTAPS-1)*SW-1:0]    hist
);
  localparam int HW = (NTAPS-1)*SW;
  localparam int EW = HW + LANES*SW;

  logic [HW-1:0] hist_q, hist_d;
  logic [EW-1:0] ext_w;

  always_comb begin
    ext_w  = {in_samples, hist_q};
    hist_d = ext_w[EW-1 -: HW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (in_valid) hist_q <= hist_d;
  end

  assign hist = hist_q;

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(hist_q)); // R6
endmodule

// File: rtl/ffe_lane.sv
module ffe_lane
  import ffe_pkg::*;
#(
  parameter int NTAPS = 16
) (
  input  logic [NTAPS*SW-1:0] win,
  input  logic [NTAPS*CW-1:0] coef,
  output logic [SW-1:0]       y,
  output logic [1:0]          sym,
  output logic [1:0]          esgn
);
  localparam int AW   = SW + CW + $clog2(NTAPS) + 1;
  localparam int HALF = 1 << (FRAC-1);

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] rnd;
  int err;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAPS; k++) begin
      acc = acc + AW'($signed(win[k*SW +: SW]) * $signed(coef[k*CW +: CW]));
    end
    rnd  = (acc + AW'(HALF)) >>> FRAC;
    y    = sat8(int'(rnd));
    sym  = slice_sym(y);
    err  = int'($signed(y)) - sym_level(sym);
    esgn = (err > 0) ? 2'b01 : ((err < 0) ? 2'b11 : 2'b00);
  end
endmodule

// File: rtl/ffe_lms.sv
module ffe_lms
  import ffe_pkg::*;
#(
  parameter int LANES = 4,
  parameter int NTAPS = 16,
  parameter int MAIN  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          upd_en,
  input  logic [2:0]                    mu,
  input  logic [LANES*NTAPS*SW-1:0]     win_all,
  input  logic [2*LANES-1:0]            esg_all,
  output logic [NTAPS*CW-1:0]           coef
);
  logic [NTAPS*CW-1:0] w_q, w_d;
  int step;
  int vote;
  int nv;

  always_comb begin
    step = 1 << (MU_MAX - ((int'(mu) > MU_MAX) ? MU_MAX : int'(mu)));
    w_d  = w_q;
    for (int k = 0; k < NTAPS; k++) begin
      vote = 0;
      for (int i = 0; i < LANES; i++) begin
        vote = vote + sgn_val(esg_all[2*i +: 2]) *
                      sgn_val(sgn_code(win_all[(i*NTAPS+k)*SW +: SW]));
      end
      nv = int'($signed(w_q[k*CW +: CW]));
      if (vote > 0)      nv = nv - step;
      else if (vote < 0) nv = nv + step;
      w_d[k*CW +: CW] = sat8(nv);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAPS; k++)
        w_q[k*CW +: CW] <= (k == MAIN) ? CW'(UNITY) : '0;
    end else if (upd_en) begin
      w_q <= w_d;
    end
  end

  assign coef = w_q;

  AST_TAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(w_q)); // R9

  for (genvar k = 0; k < NTAPS; k++) begin : g_step_chk
    AST_TAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> ((int'($signed(w_q[k*CW +: CW])) - int'($signed($past(w_q[k*CW +: CW])))) <= 64) &&
                 ((int'($signed(w_q[k*CW +: CW])) - int'($signed($past(w_q[k*CW +: CW])))) >= -64)); // R7
  end
endmodule

// File: rtl/ffe_pam4_top.sv
module ffe_pam4_top
  import ffe_pkg::*;
#(
  parameter int LANES = 4,
  parameter int NTAPS = 16,
  parameter int MAIN  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [LANES*8-1:0]    in_samples,
  input  logic                  adapt_en,
  input  logic [2:0]            mu_shift,
  output logic                  out_valid,
  output logic [LANES*8-1:0]    eq_out,
  output logic [LANES*2-1:0]    sym_out,
  output logic [NTAPS*8-1:0]    taps
);
  localparam int HN   = NTAPS - 1;
  localparam int EXTN = HN + LANES;

  logic [HN*SW-1:0]             hist;
  logic [EXTN*SW-1:0]           ext;
  logic [LANES*NTAPS*SW-1:0]    win_all;
  logic [LANES*SW-1:0]          y_all;
  logic [2*LANES-1:0]           sym_all;
  logic [2*LANES-1:0]           esg_all;

  logic                         vld_q;
  logic [LANES*SW-1:0]          eq_q, eq_d;
  logic [2*LANES-1:0]           sym_q, sym_d;

  assign ext = {in_samples, hist};

  ffe_history #(.LANES(LANES), .NTAPS(NTAPS)) u_hist (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_samples(in_samples), .hist(hist)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      assign win_all[(i*NTAPS+k)*SW +: SW] = ext[(HN+i-k)*SW +: SW];
    end
    ffe_lane #(.NTAPS(NTAPS)) u_lane (
      .win (win_all[i*NTAPS*SW +: NTAPS*SW]),
      .coef(taps),
      .y   (y_all[i*SW +: SW]),
      .sym (sym_all[2*i +: 2]),
      .esgn(esg_all[2*i +: 2])
    );
  end

  ffe_lms #(.LANES(LANES), .NTAPS(NTAPS), .MAIN(MAIN)) u_lms (
    .clk(clk), .rst_n(rst_n), .upd_en(in_valid & adapt_en),
    .mu(mu_shift), .win_all(win_all), .esg_all(esg_all), .coef(taps)
  );

  always_comb begin
    eq_d  = eq_q;
    sym_d = sym_q;
    if (in_valid) begin
      eq_d  = y_all;
      sym_d = sym_all;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      eq_q  <= '0;
      sym_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        eq_q  <= eq_d;
        sym_q <= sym_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign eq_out    = eq_q;
  assign sym_out   = sym_q;

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R5
  AST_IDLE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(eq_out) && $stable(sym_out))); // R5
  AST_TOP_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($signed(eq_out[SW-1:0]) >= 8'sd64)) |-> (sym_out[1:0] == 2'b10)); // R4
endmodule

// File: tb/tb_ffe_pam4_top.sv
`timescale 1ns/1ps
module tb_ffe_pam4_top;
  localparam int LANES = 4;
  localparam int NTAPS = 16;
  localparam int MAIN  = 2;
  localparam int HN    = NTAPS - 1;
  localparam int NV    = 12;

  // entry: [39] valid, [38] adapt, [37:35] mu, [31:0] lanes 3..0
  localparam logic [39:0] VEC [NV] = '{
    40'h80_60_20_E0_A0,
    40'h80_A0_E0_20_60,
    40'h00_11_22_33_44,
    40'hD8_60_A0_60_A0,
    40'hD8_50_C8_18_E0,
    40'hD0_7F_80_7F_80,
    40'h80_20_20_E0_E0,
    40'h00_00_00_00_00,
    40'hE0_A0_60_E0_20,
    40'hD8_58_D0_28_B8,
    40'h80_60_60_A0_A0,
    40'hC0_7F_7F_7F_7F
  };

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [LANES*8-1:0] in_samples;
  logic adapt_en;
  logic [2:0] mu_shift;
  logic out_valid;
  logic [LANES*8-1:0] eq_out;
  logic [LANES*2-1:0] sym_out;
  logic [NTAPS*8-1:0] taps;

  always #2 clk = ~clk;

  ffe_pam4_top #(.LANES(LANES), .NTAPS(NTAPS), .MAIN(MAIN)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
    .adapt_en(adapt_en), .mu_shift(mu_shift), .out_valid(out_valid),
    .eq_out(eq_out), .sym_out(sym_out), .taps(taps)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int m_hist [HN];
  int m_w [NTAPS];
  int e_eq [LANES];
  int e_sym [LANES];

  function automatic int s8(input logic [7:0] b);
    return int'($signed(b));
  endfunction

  function automatic int sgn(input int v);
    return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
  endfunction

  function automatic int clamp(input int v);
    return (v > 127) ? 127 : ((v < -128) ? -128 : v);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int j = 0; j < HN; j++) m_hist[j] = 0;
    for (int k = 0; k < NTAPS; k++) m_w[k] = (k == MAIN) ? 64 : 0;
    for (int i = 0; i < LANES; i++) begin e_eq[i] = 0; e_sym[i] = 0; end
  endtask

  task automatic check_taps(input string req);
    for (int k = 0; k < NTAPS; k++)
      check(s8(taps[k*8 +: 8]) == m_w[k], req, $sformatf("tap %0d", k), s8(taps[k*8 +: 8]), m_w[k]);
  endtask

  // drive one cycle (called at a falling edge), then check at the next falling edge
  task automatic apply(input bit vld, input bit aen, input logic [2:0] mu, input logic [31:0] smp, input string treq);
    int ext [HN+LANES];
    int ye [LANES];
    int eg [LANES];
    int acc, y, lvl, sy, vote, step;
    for (int j = 0; j < HN; j++) ext[j] = m_hist[j];
    for (int i = 0; i < LANES; i++) ext[HN+i] = s8(smp[i*8 +: 8]);
    for (int i = 0; i < LANES; i++) begin
      acc = 0;
      for (int k = 0; k < NTAPS; k++) acc += m_w[k] * ext[HN+i-k];
      y = clamp((acc + 32) >>> 6);
      if (y >= 64)       begin sy = 2; lvl = 96;  end
      else if (y >= 0)   begin sy = 3; lvl = 32;  end
      else if (y >= -64) begin sy = 1; lvl = -32; end
      else               begin sy = 0; lvl = -96; end
      ye[i] = y; eg[i] = sgn(y - lvl);
      if (vld) begin e_eq[i] = y; e_sym[i] = sy; end
    end
    in_valid = vld; adapt_en = aen; mu_shift = mu; in_samples = smp;
    @(posedge clk);
    @(negedge clk);
    if (vld && aen) begin
      step = 1 << (6 - ((int'(mu) > 6) ? 6 : int'(mu)));
      for (int k = 0; k < NTAPS; k++) begin
        vote = 0;
        for (int i = 0; i < LANES; i++) vote += eg[i] * sgn(ext[HN+i-k]);
        if (vote > 0) m_w[k] = clamp(m_w[k] - step);
        else if (vote < 0) m_w[k] = clamp(m_w[k] + step);
      end
    end
    if (vld) for (int j = 0; j < HN; j++) m_hist[j] = ext[LANES+j];
    check(out_valid == vld, "R5", "out_valid", int'(out_valid), int'(vld));
    for (int i = 0; i < LANES; i++) begin
      // R2/R3/R10: outputs built from the taps before this block's update; R6 via history
      check(s8(eq_out[i*8 +: 8]) == e_eq[i], "R2/R3/R6/R10", $sformatf("eq lane %0d", i), s8(eq_out[i*8 +: 8]), e_eq[i]);
      check(int'(sym_out[i*2 +: 2]) == e_sym[i], "R4", $sformatf("sym lane %0d", i), int'(sym_out[i*2 +: 2]), e_sym[i]);
    end
    check_taps(treq);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; adapt_en = 1'b0; mu_shift = 3'd0; in_samples = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(eq_out == '0, "R1", "eq_out in reset", int'(eq_out), 0);
    check(sym_out == '0, "R1", "sym_out in reset", int'(sym_out), 0);
    check_taps("R1");
    rst_n = 1'b1;

    // table walk: R7 on adapting entries, R9 on the others
    for (int v = 0; v < NV; v++)
      apply(VEC[v][39], VEC[v][38], VEC[v][37:35], VEC[v][31:0], "R7/R9");

    // R8: large steps with small positive samples drive taps into the upper clamp
    for (int r = 0; r < 6; r++)
      apply(1'b1, 1'b1, 3'd0, 32'h10_10_10_10, "R8");
    apply(1'b1, 1'b1, 3'd7, 32'h90_90_90_90, "R7/R8");

    // R9: valid blocks with adaptation off leave taps
    apply(1'b1, 1'b0, 3'd0, 32'h60_A0_20_E0, "R9");
    apply(1'b0, 1'b1, 3'd0, 32'h7F_7F_7F_7F, "R9");

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    model_reset();
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check_taps("R1");
    @(negedge clk);
    rst_n = 1'b1;
    apply(1'b1, 1'b1, 3'd6, 32'h20_60_E0_A0, "R1/R7");
    apply(1'b1, 1'b1, 3'd6, 32'hA0_60_20_E0, "R7/R10");
    in_valid = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R5 watchdog: actual 0 expected 1 (run did not finish)");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule